// File: doc/BRIEF.md
# Stalling Memory-Request Pipeline Model

This block is a three-slot abstraction of an instruction pipeline that keeps only the traffic between instructions and the memory controllers. It models nothing else. Decoded instructions arrive as one strobe line per opcode. An elaboration-time table says whether each opcode reads, writes, does both or does neither. The first slot raises a read request for instructions that read. The middle slot only holds instructions on their way to the write slot. The last slot raises a write request.

Requests stay up until the memory side answers with a ready that is sampled on the clock edge. While an outstanding request has no ready, the block raises a global stall. During a stall every slot holds its contents and new strobes are not taken in. An instruction that needs no write leaves the pipeline once its read, if it has one, is done. An instruction that needs a write travels on to the write slot. The block is meant to be wired to memory-controller models so that instruction sequences can be produced that drive those controllers into chosen request and ready patterns.

Top module: `mem_req_pipe`

## Requirements
- R1: A synchronous reset empties all three slots, so that in the cycle after reset `rd_req`, `wr_req` and `stall` are all low.
- R2: Strobe line i stands for opcode i. With the default table, opcode bit 0 set means the instruction reads and opcode bit 1 set means it writes. Opcodes 0, 1, 2 and 3 (mod 4) are therefore none, read, write and read-plus-write.
- R3: A reading instruction strobed in cycle c, with stall low, drives `rd_req` high in cycle c+1.
- R4: `rd_req` stays high in every cycle until `rd_ready` is high in a cycle where it is requested. After that the same instruction does not request a read again.
- R5: In any cycle where `rd_req` is high and `rd_ready` is low, `stall` is high in that same cycle.
- R6: During a stall no slot advances. A writing instruction behind a stalled read reaches the write slot correspondingly later.
- R7: Strobes applied while `stall` is high are ignored, and no request ever results from them.
- R8: A writing instruction strobed in cycle c, with no stall in cycles c+1 and c+2, drives `wr_req` high in cycle c+3. It issues no read unless R2 says it reads.
- R9: An instruction that needs neither reads nor writes issues no request and leaves in one cycle.
- R10: In any cycle where `wr_req` is high and `wr_ready` is low, `stall` is high. A write acknowledged during a stall caused by a read is not requested again. A read acknowledged during a stall caused by a write is not requested again either.
- R11: Instructions that only read never produce `wr_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_strobe | input | 2**OP_W | One strobe per opcode, at most one high, only while stall is low |
| rd_ready | input | 1 | Read acknowledgement from the memory side |
| wr_ready | input | 1 | Write acknowledgement from the memory side |
| rd_req | output | 1 | Read request from the first slot |
| wr_req | output | 1 | Write request from the last slot |
| stall | output | 1 | Pipeline frozen; no new strobe accepted |

## Verification
The bench builds the block with a 3-bit opcode field and the default pattern of read and write bits. All eight strobe lines, each of the four need combinations twice over, are then reachable in a short run. Directed sequences line up the awkward overlaps: a read stalled while a write waits behind it, and a write stalled while a read is acknowledged in the first slot. They also cover strobes pushed in during a stall. A stretch of random strobes and ready patterns then runs against a behavioural model and mixes these cases freely.

// File: rtl/mem_req_pipe_pkg.sv
package mem_req_pipe_pkg;

    // One pipeline slot: occupancy, memory needs, and whether its
    // request has already been answered while the pipe was frozen.
    typedef struct packed {
        logic valid;
        logic need_rd;
        logic need_wr;
        logic acked;
    } slot_t;

    typedef struct packed {
        slot_t s0;   // read slot
        slot_t s1;   // holding slot
        slot_t s2;   // write slot
    } pipe_t;

    localparam slot_t SLOT_EMPTY = '0;

endpackage

// File: rtl/mem_req_pipe_decode.sv
module mem_req_pipe_decode #(
    parameter int                 OP_W    = 6,
    parameter int                 NUM_OPS = 1 << OP_W,
    parameter logic [NUM_OPS-1:0] RD_NEED = '0,
    parameter logic [NUM_OPS-1:0] WR_NEED = '0
) (
    input  logic [NUM_OPS-1:0] strobe,
    output logic               hit,
    output logic               need_rd,
    output logic               need_wr
);

    logic [OP_W-1:0] op;

    // one-hot to binary opcode
    always_comb begin
        op = '0;
        for (int i = 0; i < NUM_OPS; i++) begin
            if (strobe[i]) begin
                op = op | OP_W'(i);
            end
        end
    end

    // need table lookup; result is registered by the read slot
    always_comb begin
        hit     = |strobe;
        need_rd = hit & RD_NEED[op];
        need_wr = hit & WR_NEED[op];
    end

endmodule

// File: rtl/mem_req_pipe_port.sv
module mem_req_pipe_port
    import mem_req_pipe_pkg::*;
#(
    parameter bit IS_WRITE = 1'b0
) (
    input  slot_t slot,
    input  logic  ready,
    output logic  req,
    output logic  blocked,
    output logic  acked_now
);

    logic need;

    generate
        if (IS_WRITE) begin : g_wr
            assign need = slot.need_wr;
        end else begin : g_rd
            assign need = slot.need_rd;
        end
    endgenerate

    assign req       = slot.valid & need & ~slot.acked;
    assign blocked   = req & ~ready;
    assign acked_now = req & ready;

endmodule

// File: rtl/mem_req_pipe.sv
module mem_req_pipe
    import mem_req_pipe_pkg::*;
#(
    parameter  int                 OP_W    = 6,
    localparam int                 NUM_OPS = 1 << OP_W,
    parameter  logic [NUM_OPS-1:0] RD_NEED = {(NUM_OPS/2){2'b10}},
    parameter  logic [NUM_OPS-1:0] WR_NEED = {(NUM_OPS/4){4'b1100}}
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_OPS-1:0] instr_strobe,
    input  logic               rd_ready,
    input  logic               wr_ready,
    output logic               rd_req,
    output logic               wr_req,
    output logic               stall
);

    pipe_t st_d, st_q;

    logic new_hit, new_rd, new_wr;
    logic rd_blocked, wr_blocked, rd_ack, wr_ack;

    mem_req_pipe_decode #(
        .OP_W   (OP_W),
        .NUM_OPS(NUM_OPS),
        .RD_NEED(RD_NEED),
        .WR_NEED(WR_NEED)
    ) i_decode (
        .strobe (instr_strobe),
        .hit    (new_hit),
        .need_rd(new_rd),
        .need_wr(new_wr)
    );

    mem_req_pipe_port #(.IS_WRITE(1'b0)) i_rd_port (
        .slot     (st_q.s0),
        .ready    (rd_ready),
        .req      (rd_req),
        .blocked  (rd_blocked),
        .acked_now(rd_ack)
    );

    mem_req_pipe_port #(.IS_WRITE(1'b1)) i_wr_port (
        .slot     (st_q.s2),
        .ready    (wr_ready),
        .req      (wr_req),
        .blocked  (wr_blocked),
        .acked_now(wr_ack)
    );

    assign stall = rd_blocked | wr_blocked;

    always_comb begin
        st_d = st_q;
        if (stall) begin
            // frozen: only remember answers that did arrive
            if (rd_ack) begin
                st_d.s0.acked = 1'b1;
            end
            if (wr_ack) begin
                st_d.s2.acked = 1'b1;
            end
        end else begin
            st_d.s2       = st_q.s1;
            st_d.s2.acked = 1'b0;
            st_d.s1       = (st_q.s0.valid && st_q.s0.need_wr) ? st_q.s0 : SLOT_EMPTY;
            st_d.s1.acked = 1'b0;
            st_d.s0.valid   = new_hit;
            st_d.s0.need_rd = new_rd;
            st_d.s0.need_wr = new_wr;
            st_d.s0.acked   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mem_req_pipe_chk.sv
module mem_req_pipe_chk #(
    parameter int                 NUM_OPS = 64,
    parameter logic [NUM_OPS-1:0] RD_NEED = '0
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_OPS-1:0] instr_strobe,
    input logic               rd_ready,
    input logic               wr_ready,
    input logic               rd_req,
    input logic               wr_req,
    input logic               stall
);

    p_reset_empty_r1: assert property (@(posedge clk)
        $past(rst) |-> (!rd_req && !wr_req && !stall));

    p_read_issue_r3: assert property (@(posedge clk) disable iff (rst)
        (!stall && |(instr_strobe & RD_NEED)) |=> rd_req);

    p_read_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ready) |=> rd_req);

    p_read_stall_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ready) |-> stall);

    p_write_stall_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ready) |-> stall);

    p_write_once_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wr_ready && stall) |=> !wr_req);

    p_read_once_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_ready && stall) |=> !rd_req);

endmodule

bind mem_req_pipe mem_req_pipe_chk #(
    .NUM_OPS(NUM_OPS),
    .RD_NEED(RD_NEED)
) i_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_strobe(instr_strobe),
    .rd_ready    (rd_ready),
    .wr_ready    (wr_ready),
    .rd_req      (rd_req),
    .wr_req      (wr_req),
    .stall       (stall)
);

// File: tb/test_mem_req_pipe.sv
module test_mem_req_pipe;

    localparam int CLK_PERIOD = 10;
    localparam int OP_W       = 3;
    localparam int NUM_OPS    = 1 << OP_W;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_OPS-1:0] instr_strobe = '0;
    logic               rd_ready = 1'b1;
    logic               wr_ready = 1'b1;
    logic               rd_req, wr_req, stall;

    int checks = 0;
    int errors = 0;

    // behavioural reference: op held per position, -1 when empty
    int m_op [3];
    bit m_done [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_req_pipe #(
        .OP_W   (OP_W),
        .RD_NEED(8'hAA),
        .WR_NEED(8'hCC)
    ) i_mem_req_pipe (
        .clk         (clk),
        .rst         (rst),
        .instr_strobe(instr_strobe),
        .rd_ready    (rd_ready),
        .wr_ready    (wr_ready),
        .rd_req      (rd_req),
        .wr_req      (wr_req),
        .stall       (stall)
    );

    // R2: bit 0 of the opcode means read, bit 1 means write
    function automatic bit reads(input int op);
        return op >= 0 && op[0];
    endfunction
    function automatic bit writes(input int op);
        return op >= 0 && op[1];
    endfunction

    task automatic chk(input string tag, input string what, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 3; i++) begin
            m_op[i]   = -1;
            m_done[i] = 1'b0;
        end
    endtask

    // one clock: drive inputs, compare outputs mid-cycle, advance model
    task automatic step(input int op, input bit rr, input bit wr, input string tag);
        bit e_rd, e_wr, e_st;
        @(negedge clk);
        instr_strobe = (op >= 0) ? NUM_OPS'(1) << op : '0;
        rd_ready     = rr;
        wr_ready     = wr;
        #1;
        e_rd = reads(m_op[0]) && !m_done[0];
        e_wr = (m_op[2] >= 0) && !m_done[2];
        e_st = (e_rd && !rr) || (e_wr && !wr);
        chk(tag, "rd_req", rd_req, e_rd);
        chk(tag, "wr_req", wr_req, e_wr);
        chk(tag, "stall", stall, e_st);
        if (e_st) begin
            if (e_rd && rr) m_done[0] = 1'b1;
            if (e_wr && wr) m_done[2] = 1'b1;
        end else begin
            m_op[2]   = m_op[1];
            m_done[2] = 1'b0;
            m_op[1]   = writes(m_op[0]) ? m_op[0] : -1;
            m_op[0]   = op;
            m_done[0] = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_clear();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "rd_req", rd_req, 1'b0);
        chk("R1", "wr_req", wr_req, 1'b0);
        chk("R1", "stall", stall, 1'b0);
        rst = 1'b0;

        // R9: no-need opcode, then idle
        step(0, 1, 1, "R9");
        step(-1, 1, 1, "R9");
        step(4, 1, 1, "R9");
        step(-1, 1, 1, "R9");
        // R3 / R11: read-only opcodes
        step(1, 1, 1, "R3");
        step(5, 1, 1, "R3");
        step(-1, 1, 1, "R11");
        step(-1, 1, 1, "R11");
        step(-1, 1, 1, "R11");
        // R8: write-only and read-plus-write
        step(2, 1, 1, "R8");
        step(3, 1, 1, "R8");
        step(-1, 1, 1, "R8");
        step(-1, 1, 1, "R8");
        step(-1, 1, 1, "R8");
        step(-1, 1, 1, "R8");

        // R4 R5 R6 R7: read held off, a writer behind it, strobe in stall
        step(2, 1, 1, "R6");
        step(7, 1, 1, "R6");
        step(-1, 0, 1, "R5");
        step(6, 0, 1, "R7");
        step(1, 0, 1, "R7");
        step(-1, 1, 1, "R4");
        step(-1, 1, 1, "R6");
        step(-1, 1, 1, "R6");
        step(-1, 1, 1, "R7");
        step(-1, 1, 1, "R7");

        // R10: write stalled while a read in the first slot is answered
        step(2, 1, 1, "R10");
        step(-1, 1, 1, "R10");
        step(1, 1, 1, "R10");
        step(-1, 1, 0, "R10");
        step(-1, 0, 0, "R10");
        step(-1, 0, 1, "R10");
        step(-1, 1, 1, "R10");
        step(-1, 1, 1, "R10");
        // R10: read stalled while the write slot is answered
        step(3, 1, 1, "R10");
        step(3, 1, 1, "R10");
        step(1, 1, 1, "R10");
        step(-1, 0, 1, "R10");
        step(-1, 0, 1, "R10");
        step(-1, 1, 1, "R10");
        step(-1, 1, 1, "R10");
        step(-1, 1, 1, "R10");

        // mixed traffic covering R2 R3 R7 R8 R10 together
        for (int n = 0; n < 600; n++) begin
            bit rr, wr;
            int op;
            rr = ($urandom % 4) != 0;
            wr = ($urandom % 4) != 0;
            op = (($urandom % 3) != 0) ? int'($urandom % NUM_OPS) : -1;
            step(op, rr, wr, "R2");
        end

        // R1: reset mid-traffic empties everything
        step(3, 1, 1, "R1");
        step(2, 1, 1, "R1");
        @(negedge clk);
        rst = 1'b1;
        instr_strobe = '0;
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        chk("R1", "rd_req", rd_req, 1'b0);
        chk("R1", "wr_req", wr_req, 1'b0);
        chk("R1", "stall", stall, 1'b0);
        step(-1, 1, 1, "R1");
        step(-1, 1, 1, "R1");
        step(-1, 1, 1, "R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule